// File: doc/BRIEF.md
# Serial Control Port with Status Readback for a Radio Transceiver

This block is the configuration front end of a radio transceiver. A host controller drives three slow lines: a serial clock, a serial data line and a latch strobe. While the latch is low, each rising edge of the serial clock shifts one data bit into a 16-bit frame, most significant bit first. A rising latch then writes the frame's upper twelve bits into one of six configuration registers, chosen by the frame's low four bits. The register contents leave the block as plain output fields. A few fields are decoded here: the operating mode, the oscillator output gate, the calibration select and the receive-data polarity.

A latched frame with address zero writes nothing. It turns the shared data line around, and the block returns a 12-bit status word on the line as an open-drain driver: it pulls low for a 0 and releases for a 1. After twelve serial clock rising edges the port falls back to write mode by itself. Holding serial clock and latch high together clears the mode and flag-select bits of the mode register. All three serial lines are synchronised into the fast system clock. The serial interface has no back-pressure: the host sets the pace, and the block accepts every edge it sees.

Top module: `tcvr_ctrl_port`

## Requirements
- R1: Bits are taken on rising serial clock edges only while the latch is low, first bit into frame bit 15. Frame bits 3:0 form the address.
- R2: A latch rising edge after 16 or more shifted bits copies frame bits 15:4 to the register at that address (0xF syn_lo, 0x7 syn_hi, 0xB xtal_cfg, 0x3 vco_cfg, 0xD rx_cfg, 0x5 mode_cfg). The other registers keep their values.
- R3: A latch rising edge after fewer than 16 shifted bits writes nothing and clears the bit count, so later bits start a new frame.
- R4: A latched address 0x0 enters read mode. The status bit 0 is presented first, and each falling serial clock edge moves to the next bit. The line is pulled low for a 0 and released for a 1. In write mode the line is always released.
- R5: Read mode ends by itself on the 12th rising serial clock edge after entry. The line is then released and normal writes resume.
- R6: Status word bit 6 carries a flag chosen by mode_cfg frame bits 10:9: 10 selects sys_err_i, 11 selects batt_ok_i, 00 or 01 selects pll_lock_i. Every other status bit reads 0, including address bits 3:0.
- R7: When serial clock and latch are both high for at least 2 consecutive system clocks, mode_cfg frame bits 9:4 are cleared. Frame bits 15:10 are kept. This clear overrides a write to mode_cfg that the same latch made.
- R8: When mode_cfg frame bit 6 is 1, op_mode_o is taken from frame bits 5:4. When it is 0, op_mode_o is taken from mode_pin_i. The codes are 00 sleep, 01 standby, 10 transmit, 11 receive.
- R9: When mode_cfg frame bit 8 is 1, xo_clk_o is held low. When it is 0, xo_clk_o follows xo_clk_i. vco_autocal_o equals mode_cfg frame bit 7.
- R10: When xtal_cfg frame bit 14 is 1, rx_data_o equals rx_raw_i. When it is 0, rx_data_o is the inverse of rx_raw_i.
- R11: After reset all six registers are zero, the port is in write mode and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| slat_i | input | 1 | Latch strobe from the host |
| sdi_i | input | 1 | Serial data line as seen at the pin |
| sdo_pull_o | output | 1 | Open-drain pull-down enable for the data line |
| mode_pin_i | input | 2 | External operating mode pins |
| pll_lock_i | input | 1 | Synthesizer lock flag |
| sys_err_i | input | 1 | System error flag |
| batt_ok_i | input | 1 | Supply above threshold flag |
| rx_raw_i | input | 1 | Demodulated receive data |
| rx_data_o | output | 1 | Receive data after polarity select |
| xo_clk_i | input | 1 | Oscillator signal to buffer |
| xo_clk_o | output | 1 | Gated oscillator output |
| op_mode_o | output | 2 | Effective operating mode |
| vco_autocal_o | output | 1 | Automatic VCO band calibration select |
| syn_lo_o | output | 12 | Register 0xF, frame bits 15:4 |
| syn_hi_o | output | 12 | Register 0x7, frame bits 15:4 |
| xtal_cfg_o | output | 12 | Register 0xB, frame bits 15:4 |
| vco_cfg_o | output | 12 | Register 0x3, frame bits 15:4 |
| rx_cfg_o | output | 12 | Register 0xD, frame bits 15:4 |
| mode_cfg_o | output | 12 | Register 0x5, frame bits 15:4 |

## Verification
A latch that commits a mode_cfg frame and the combined clock-and-latch clear can land on the same register within a few system clocks. This happens when the host raises the latch while the last serial clock pulse is still high. The bench provokes this by leaving the 16th clock high and raising the latch over it. It then expects the new frame's bits 15:10 to be kept and bits 9:4 to be zero. A separate hold of both lines, with no preceding frame, shows that the clear acts alone and leaves the upper bits untouched.

// File: rtl/tcvr_ctrl_pkg.sv
package tcvr_ctrl_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 4;
  localparam int FIELD_W = FRAME_W - ADDR_W;
  localparam int NREG    = 6;
  localparam int STAT_W  = 12;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int SIDX_W  = $clog2(STAT_W);

  // register slots and their bus addresses
  localparam int IDX_SYN_LO = 0;
  localparam int IDX_SYN_HI = 1;
  localparam int IDX_XTAL   = 2;
  localparam int IDX_VCO    = 3;
  localparam int IDX_RX     = 4;
  localparam int IDX_MODE   = 5;
  localparam logic [ADDR_W-1:0] REG_ADDR [NREG] = '{4'hF, 4'h7, 4'hB, 4'h3, 4'hD, 4'h5};
  localparam logic [ADDR_W-1:0] RD_ADDR = '0;

  // field positions inside a stored word (frame bit minus ADDR_W)
  localparam int F_MD_LO  = 0;
  localparam int F_MD_HI  = 1;
  localparam int F_EXT    = 2;
  localparam int F_CAL    = 3;
  localparam int F_XOD    = 4;
  localparam int F_SC_LO  = 5;
  localparam int F_SC_HI  = 6;
  localparam int F_CLR_LO = 0;
  localparam int F_CLR_HI = 5;
  localparam int F_DP     = 10;
  localparam int STAT_FLAG = 6;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [NREG-1:0][FIELD_W-1:0] regfile_t;
endpackage

// File: rtl/tcvr_sync.sv
module tcvr_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic m1, m2, m3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        m1 <= 1'b0;
        m2 <= 1'b0;
        m3 <= 1'b0;
      end else begin
        m1 <= async_i[g];
        m2 <= m1;
        m3 <= m2;
      end
    end
    assign lvl_o[g]  = m2;
    assign rise_o[g] = m2 & ~m3;
    assign fall_o[g] = ~m2 & m3;
  end
endmodule

// File: rtl/tcvr_frame_rx.sv
module tcvr_frame_rx
  import tcvr_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_rise_i,
  input  logic              lat_rise_i,
  input  logic              lat_lvl_i,
  input  logic              dat_lvl_i,
  input  logic              busy_i,
  output logic              commit_o,
  output logic [ADDR_W-1:0] addr_o,
  output field_t            data_o
);
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0]   cnt;
  logic               full;

  assign full = (cnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (!busy_i) begin
      if (lat_rise_i) begin
        cnt <= '0;
      end else if (sclk_rise_i && !lat_lvl_i) begin
        shreg <= {shreg[FRAME_W-2:0], dat_lvl_i};
        if (!full) cnt <= cnt + 1'b1;
      end
    end
  end

  assign commit_o = lat_rise_i && !busy_i && full;
  assign addr_o   = shreg[ADDR_W-1:0];
  assign data_o   = shreg[FRAME_W-1:ADDR_W];
endmodule

// File: rtl/tcvr_regbank.sv
module tcvr_regbank
  import tcvr_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  field_t            data_i,
  input  logic              clr_i,
  output regfile_t          regs_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    field_t q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else begin
        if (commit_i && addr_i == REG_ADDR[g]) q <= data_i;
        // partial clear applies to the mode register only and wins over a write
        if (g == IDX_MODE && clr_i) q[F_CLR_HI:F_CLR_LO] <= '0;
      end
    end
    assign regs_o[g] = q;
  end
endmodule

// File: rtl/tcvr_readback.sv
module tcvr_readback
  import tcvr_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              sclk_rise_i,
  input  logic              sclk_fall_i,
  output logic              active_o,
  output logic              pull_o,
  output logic [SIDX_W-1:0] rises_o
);
  logic [STAT_W-1:0] word;
  logic [SIDX_W-1:0] bit_idx;
  logic [SIDX_W-1:0] rises;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_o <= 1'b0;
      word     <= '0;
      bit_idx  <= '0;
      rises    <= '0;
    end else if (!active_o) begin
      if (start_i) begin
        active_o <= 1'b1;
        word     <= status_i;
        bit_idx  <= '0;
        rises    <= '0;
      end
    end else if (sclk_rise_i) begin
      if (rises == SIDX_W'(STAT_W - 1)) active_o <= 1'b0;
      else rises <= rises + 1'b1;
    end else if (sclk_fall_i) begin
      if (bit_idx != SIDX_W'(STAT_W - 1)) bit_idx <= bit_idx + 1'b1;
    end
  end

  assign pull_o  = active_o & ~word[bit_idx];
  assign rises_o = rises;
endmodule

// File: rtl/tcvr_ctrl_port.sv
module tcvr_ctrl_port
  import tcvr_ctrl_pkg::*;
#(
  parameter int CLR_HOLD = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk_i,
  input  logic        slat_i,
  input  logic        sdi_i,
  output logic        sdo_pull_o,
  input  logic [1:0]  mode_pin_i,
  input  logic        pll_lock_i,
  input  logic        sys_err_i,
  input  logic        batt_ok_i,
  input  logic        rx_raw_i,
  output logic        rx_data_o,
  input  logic        xo_clk_i,
  output logic        xo_clk_o,
  output logic [1:0]  op_mode_o,
  output logic        vco_autocal_o,
  output logic [11:0] syn_lo_o,
  output logic [11:0] syn_hi_o,
  output logic [11:0] xtal_cfg_o,
  output logic [11:0] vco_cfg_o,
  output logic [11:0] rx_cfg_o,
  output logic [11:0] mode_cfg_o
);
  localparam int HOLD_W = $clog2(CLR_HOLD + 1);

  logic [2:0] s_lvl, s_rise, s_fall;
  logic       commit, rd_start, rd_active, clr;
  logic [ADDR_W-1:0] c_addr;
  field_t     c_data, mode_r;
  regfile_t   regs;
  logic [STAT_W-1:0] status;
  logic [SIDX_W-1:0] rd_rises;
  logic [HOLD_W-1:0] hold_cnt;
  logic       both_hi, flag;

  tcvr_sync #(.W(3)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sdi_i, slat_i, sclk_i}),
    .lvl_o(s_lvl), .rise_o(s_rise), .fall_o(s_fall)
  );

  tcvr_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_rise_i(s_rise[0]), .lat_rise_i(s_rise[1]),
    .lat_lvl_i(s_lvl[1]), .dat_lvl_i(s_lvl[2]),
    .busy_i(rd_active),
    .commit_o(commit), .addr_o(c_addr), .data_o(c_data)
  );

  // combined clock+latch hold detector
  assign both_hi = s_lvl[0] & s_lvl[1];
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_cnt <= '0;
    else if (!both_hi) hold_cnt <= '0;
    else if (hold_cnt != HOLD_W'(CLR_HOLD)) hold_cnt <= hold_cnt + 1'b1;
  end
  assign clr = both_hi && (hold_cnt >= HOLD_W'(CLR_HOLD - 1));

  tcvr_regbank u_regs (
    .clk(clk), .rst_n(rst_n),
    .commit_i(commit), .addr_i(c_addr), .data_i(c_data),
    .clr_i(clr), .regs_o(regs)
  );

  assign mode_r = regs[IDX_MODE];

  always_comb begin
    unique case (mode_r[F_SC_HI:F_SC_LO])
      2'b10:   flag = sys_err_i;
      2'b11:   flag = batt_ok_i;
      default: flag = pll_lock_i;
    endcase
    status = '0;
    status[STAT_FLAG] = flag;
    status[ADDR_W-1:0] = RD_ADDR;
  end

  assign rd_start = commit && (c_addr == RD_ADDR);

  tcvr_readback u_rb (
    .clk(clk), .rst_n(rst_n),
    .start_i(rd_start), .status_i(status),
    .sclk_rise_i(s_rise[0]), .sclk_fall_i(s_fall[0]),
    .active_o(rd_active), .pull_o(sdo_pull_o), .rises_o(rd_rises)
  );

  assign op_mode_o     = mode_r[F_EXT] ? mode_r[F_MD_HI:F_MD_LO] : mode_pin_i;
  assign xo_clk_o      = xo_clk_i & ~mode_r[F_XOD];
  assign vco_autocal_o = mode_r[F_CAL];
  assign rx_data_o     = regs[IDX_XTAL][F_DP] ? rx_raw_i : ~rx_raw_i;

  assign syn_lo_o   = regs[IDX_SYN_LO];
  assign syn_hi_o   = regs[IDX_SYN_HI];
  assign xtal_cfg_o = regs[IDX_XTAL];
  assign vco_cfg_o  = regs[IDX_VCO];
  assign rx_cfg_o   = regs[IDX_RX];
  assign mode_cfg_o = mode_r;
endmodule

// File: rtl/tcvr_ctrl_port_chk.sv
module tcvr_ctrl_port_chk
  import tcvr_ctrl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              sdo_pull_o,
  input logic              rd_active,
  input logic [SIDX_W-1:0] rd_rises,
  input logic              commit,
  input logic              clr,
  input regfile_t          regs,
  input logic              xo_clk_o
);
  // R4: line stays released outside read mode
  a_r4_release_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_active |-> !sdo_pull_o);

  // R5: read mode never counts past the last status bit
  a_r5_bounded_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> (rd_rises < SIDX_W'(STAT_W)));

  // R2: registers only change on a commit or a partial clear
  a_r2_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit || clr) |=> $stable(regs));

  // R7: after a clear the mode/flag-select bits are zero
  a_r7_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (regs[IDX_MODE][F_CLR_HI:F_CLR_LO] == '0));

  // R9: disabled oscillator output stays low
  a_r9_xo_forced_low: assert property (@(posedge clk) disable iff (!rst_n)
    regs[IDX_MODE][F_XOD] |-> !xo_clk_o);

  // R3: a frame is taken only outside read mode
  a_r3_no_commit_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !commit);
endmodule

bind tcvr_ctrl_port tcvr_ctrl_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sdo_pull_o(sdo_pull_o),
  .rd_active(rd_active), .rd_rises(rd_rises),
  .commit(commit), .clr(clr), .regs(regs), .xo_clk_o(xo_clk_o)
);

// File: tb/test_tcvr_ctrl_port.sv
`timescale 1ns/1ps
module test_tcvr_ctrl_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, slat = 1'b0, sdi = 1'b0;
  logic sdo_pull;
  logic [1:0] mode_pin = 2'b10;
  logic pll_lock = 1'b0, sys_err = 1'b0, batt_ok = 1'b0;
  logic rx_raw = 1'b1, rx_data, xo_in = 1'b1, xo_out;
  logic [1:0] op_mode;
  logic autocal;
  logic [11:0] syn_lo, syn_hi, xtal_cfg, vco_cfg, rx_cfg, mode_cfg;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  tcvr_ctrl_port i_tcvr_ctrl_port (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .slat_i(slat), .sdi_i(sdi),
    .sdo_pull_o(sdo_pull), .mode_pin_i(mode_pin), .pll_lock_i(pll_lock),
    .sys_err_i(sys_err), .batt_ok_i(batt_ok), .rx_raw_i(rx_raw),
    .rx_data_o(rx_data), .xo_clk_i(xo_in), .xo_clk_o(xo_out),
    .op_mode_o(op_mode), .vco_autocal_o(autocal),
    .syn_lo_o(syn_lo), .syn_hi_o(syn_hi), .xtal_cfg_o(xtal_cfg),
    .vco_cfg_o(vco_cfg), .rx_cfg_o(rx_cfg), .mode_cfg_o(mode_cfg)
  );

  // writes: frame, and slot 0..5 = 0xF,0x7,0xB,0x3,0xD,0x5
  localparam logic [15:0] WR_VEC [6] = '{16'hA5CF, 16'h1237, 16'h4ABB, 16'h9C33, 16'h6E1D, 16'h0765};
  localparam int          WR_SLOT [6] = '{0, 1, 2, 3, 4, 5};
  logic [11:0] model [6];

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] slot_val(input int k);
    case (k)
      0: return syn_lo;
      1: return syn_hi;
      2: return xtal_cfg;
      3: return vco_cfg;
      4: return rx_cfg;
      default: return mode_cfg;
    endcase
  endfunction

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 15; i >= 16 - n; i--) begin
      sdi = w[i]; tick(3);
      sclk = 1'b1; tick(4);
      sclk = 1'b0; tick(3);
    end
  endtask

  task automatic latch();
    slat = 1'b1; tick(4);
    slat = 1'b0; tick(6);
  endtask

  task automatic write(input logic [15:0] w);
    send_bits(w, 16);
    latch();
  endtask

  task automatic read_status(output logic [11:0] s);
    write(16'h0000);
    for (int i = 0; i < 12; i++) begin
      s[i] = ~sdo_pull;
      sclk = 1'b1; tick(5);
      sclk = 1'b0; tick(6);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [11:0] st;
    tick(5);
    rst_n = 1'b1;
    tick(4);
    // R11: reset state
    for (int k = 0; k < 6; k++) chk("R11 reg zero", slot_val(k), 12'h000);
    chk("R11 line released", sdo_pull, 1'b0);
    chk("R11 R8 mode from pins", op_mode, 2'b10);
    chk("R11 R10 polarity 0 inverts", rx_data, 1'b0);

    // R1 R2: table walk
    for (int i = 0; i < 6; i++) begin
      write(WR_VEC[i]);
      model[WR_SLOT[i]] = WR_VEC[i][15:4];
      chk("R1 R2 table write", slot_val(WR_SLOT[i]), model[WR_SLOT[i]]);
    end
    for (int k = 0; k < 6; k++) chk("R2 others kept", slot_val(k), model[k]);
    // mode 0x076: ext=1 md=10, xo disabled, cal 0
    chk("R8 mode from register", op_mode, 2'b10);
    chk("R9 xo forced low", xo_out, 1'b0);
    chk("R9 autocal off", autocal, 1'b0);
    chk("R10 polarity 1 passes", rx_data, 1'b1);

    // R10: polarity 0 inverts
    write(16'h0ABB);
    chk("R10 invert", rx_data, 1'b0);
    rx_raw = 1'b0; tick(2);
    chk("R10 invert low", rx_data, 1'b1);

    // R8 R9: pin source, receive code from register, xo enabled, autocal on
    write(16'h00B5);       // ext=0? bits: 0x00B -> cal=1, ext=0, md=11
    mode_pin = 2'b01; tick(2);
    chk("R8 pins standby", op_mode, 2'b01);
    chk("R9 autocal on", autocal, 1'b1);
    chk("R9 xo follows", xo_out, 1'b1);
    write(16'h0075);       // ext=1 md=11
    chk("R8 register receive", op_mode, 2'b11);

    // R3: short frames are dropped and the count restarts
    send_bits(16'hFFFF, 8); latch();
    send_bits(16'h03C0, 10); latch();
    chk("R3 short frames ignored", syn_lo, model[0]);
    write(16'h5A6F);
    chk("R3 full frame after", syn_lo, 12'h5A6);

    // R4 R6: status readback
    pll_lock = 1'b1; sys_err = 1'b0; batt_ok = 1'b0;
    write(16'h0205);
    read_status(st);
    chk("R4 R6 pll flag set", st, 12'h040);
    chk("R5 released after read", sdo_pull, 1'b0);
    write(16'h1117);
    chk("R5 write after read", syn_hi, 12'h111);
    pll_lock = 1'b0; sys_err = 1'b1; batt_ok = 1'b1;
    read_status(st);
    chk("R6 pll flag clear", st, 12'h000);
    write(16'h0405);
    read_status(st);
    chk("R6 sys_err flag", st, 12'h040);
    pll_lock = 1'b1; batt_ok = 1'b0;
    write(16'h0605);
    read_status(st);
    chk("R6 battery flag", st, 12'h000);
    chk("R5 back to write mode", sdo_pull, 1'b0);

    // R7: hold both lines high alone
    write(16'hFFF5);
    chk("R7 setup", mode_cfg, 12'hFFF);
    slat = 1'b1; tick(3);
    sclk = 1'b1; tick(8);
    sclk = 1'b0; slat = 1'b0; tick(6);
    chk("R7 clear bits 9:4", mode_cfg, 12'hFC0);
    chk("R7 R8 pins after clear", op_mode, mode_pin);

    // R7 R2: latch raised over the last clock high
    send_bits(16'hAB05, 15);
    sdi = 1'b1; tick(3);
    sclk = 1'b1; tick(4);
    slat = 1'b1; tick(8);
    sclk = 1'b0; slat = 1'b0; tick(6);
    chk("R7 commit then clear", mode_cfg, 12'hA80);
    chk("R2 other regs unaffected", syn_lo, 12'h5A6);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule